// File: doc/BRIEF.md
# Edge-Selectable Interrupting GPIO Port

This block is a general-purpose I/O port of `WIDTH` lines (eight by default). Three registers set its behaviour: an output-value register, a direction register that picks, line by line, whether the pad is driven, and an edge-select register that picks which transition of a line raises an interrupt event. Software reads and writes these registers over a small synchronous register bus. A read of the value register returns a mix: driven lines give back their stored bit, and undriven lines give the pad level as seen through the synchronizer.

Every pad level passes through a two-flop synchronizer. A transition detector follows it and gives a one-clock event pulse per line. That pulse feeds an interrupt controller outside this block. The detector compares the synchronized level with the edge-select bit through an exclusive-OR. An event is the high-to-low fall of that XOR. A write to the edge-select register can therefore raise an event even while the pad is steady. Two chosen lines (3 and 4 by default) also export their synchronized level, so a neighbouring timer can use them as gate or count inputs.

Top module: `edge_gpio_port`

## Requirements
- R1: After reset the value, direction and edge-select registers are all zero, no pad is driven (`pin_oe` = 0), `pin_out` = 0 and no event is raised.
- R2: A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Address 0 selects the value register, 1 the direction register and 2 the edge-select register. Address 3 reads as zero, and a write to it changes no register.
- R3: `pin_oe` bit i equals direction bit i (1 = driven output, 0 = high-impedance input), and `pin_out` equals the value register.
- R4: A write to the value register leaves the direction register and `pin_oe` unchanged, so lines set as inputs stay undriven.
- R5: A read of address 0 returns, for each line, the value-register bit where the direction bit is 1 and the synchronized pad level where it is 0. `bus_rdata` is zero while `bus_sel` is low.
- R6: A pad change that is stable before a clock edge shows in the synchronized level (read-back, aux outputs, detector) only after the second clock edge.
- R7: With edge-select bit 0, a 1-to-0 change of the synchronized level raises an event on that line, and a 0-to-1 change raises none.
- R8: With edge-select bit 1, a 0-to-1 change of the synchronized level raises an event, and a 1-to-0 change raises none.
- R9: Each detected transition gives an event pulse exactly one clock long. A line never shows an event in two consecutive cycles.
- R10: A change of an edge-select bit while the pad is steady raises one event in the cycle after the write, when the new bit equals the synchronized level of that line.
- R11: `aux_lvl[0]` and `aux_lvl[1]` carry the synchronized levels of lines `AUX_A` (3) and `AUX_B` (4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data (combinational from address) |
| pin_in | input | WIDTH | Pad levels, asynchronous |
| pin_out | output | WIDTH | Value driven onto pads |
| pin_oe | output | WIDTH | Per-line output enable |
| edge_evt | output | WIDTH | One-cycle interrupt event per line |
| aux_lvl | output | 2 | Synchronized levels of the two auxiliary lines |

## Verification
On every cycle, the assertions check that writes to the value register or to the unused address leave the other registers alone. They also check that no line pulses in two consecutive cycles. Where the edge-select bit is steady, they check that an event matches a level change in the selected direction. The latency through the synchronizer, the mixed read-back and the event raised by rewriting the edge-select register can only be shown by the bench scenarios. A cycle-by-cycle model compares them against these scenarios.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_VALUE = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_EDGE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_level_sync.sv
module gpio_level_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_nx;

  always_comb begin
    stage_nx[0] = raw_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_nx[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nx;
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_lvl_i,
  output logic [W-1:0]      value_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      edge_o,
  output logic [W-1:0]      rdata_o
);
  reg_sel_e    which;
  logic        wr_en;
  logic        value_en, dir_en, edge_en;
  logic [W-1:0] value_q, dir_q, edge_q;
  logic [W-1:0] value_nx, dir_nx, edge_nx;

  assign which    = reg_sel_e'(addr_i);
  assign wr_en    = sel_i & wr_i;
  assign value_en = wr_en && (which == SEL_VALUE);
  assign dir_en   = wr_en && (which == SEL_DIR);
  assign edge_en  = wr_en && (which == SEL_EDGE);

  always_comb begin
    value_nx = value_en ? wdata_i : value_q;
    dir_nx   = dir_en   ? wdata_i : dir_q;
    edge_nx  = edge_en  ? wdata_i : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '0;
      edge_q  <= '0;
    end else begin
      value_q <= value_nx;
      dir_q   <= dir_nx;
      edge_q  <= edge_nx;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (which)
        SEL_VALUE: rdata_o = (value_q & dir_q) | (pin_lvl_i & ~dir_q);
        SEL_DIR:   rdata_o = dir_q;
        SEL_EDGE:  rdata_o = edge_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign value_o = value_q;
  assign dir_o   = dir_q;
  assign edge_o  = edge_q;

  // R4
  value_wr_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && which == SEL_VALUE) |=> $stable(dir_q));

  // R2
  unused_addr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && which == SEL_NONE) |=> ($stable(value_q) && $stable(dir_q) && $stable(edge_q)));
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_sel_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] cmp_now;
  logic [W-1:0] cmp_q;

  assign cmp_now = lvl_i ^ edge_sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else        cmp_q <= cmp_now;
  end

  assign evt_o = cmp_q & ~cmp_now;

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & $past(evt_o)) == '0));

  for (genvar i = 0; i < W; i++) begin : g_line
    // R7 R8
    edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[i] && $stable(edge_sel_i[i])) |->
        (lvl_i[i] == edge_sel_i[i] && $past(lvl_i[i]) != edge_sel_i[i]));
  end
endmodule

// File: rtl/edge_gpio_port.sv
module edge_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AUX_A       = 3,
  parameter int unsigned AUX_B       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  edge_evt,
  output logic [1:0]        aux_lvl
);
  logic [WIDTH-1:0] lvl;
  logic [WIDTH-1:0] value_r, dir_r, edge_r;

  gpio_level_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (pin_in),
    .lvl_o (lvl)
  );

  gpio_ctrl_regs #(.W(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (bus_sel),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .pin_lvl_i (lvl),
    .value_o   (value_r),
    .dir_o     (dir_r),
    .edge_o    (edge_r),
    .rdata_o   (bus_rdata)
  );

  gpio_edge_detect #(.W(WIDTH)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .edge_sel_i (edge_r),
    .evt_o      (edge_evt)
  );

  assign pin_out = value_r;
  assign pin_oe  = dir_r;
  assign aux_lvl = {lvl[AUX_B], lvl[AUX_A]};
endmodule

// File: tb/edge_gpio_port_tb_top.sv
module edge_gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe, edge_evt;
  logic [1:0]   aux_lvl;

  int total = 0;
  int bad = 0;
  int evt_cnt [W];

  // behavioural model state
  logic [W-1:0] m_val, m_dir, m_edge, m_meta, m_lvl, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .edge_evt(edge_evt), .aux_lvl(aux_lvl)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_val = '0; m_dir = '0; m_edge = '0; m_meta = '0; m_lvl = '0; m_prev = '0;
    end else begin
      m_prev = m_lvl ^ m_edge;
      m_lvl  = m_meta;
      m_meta = pin_in;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          2'd0: m_val  = bus_wdata;
          2'd1: m_dir  = bus_wdata;
          2'd2: m_edge = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [W-1:0] model_rd();
    if (!bus_sel) return '0;
    case (bus_addr)
      2'd0: return (m_val & m_dir) | (m_lvl & ~m_dir);
      2'd1: return m_dir;
      2'd2: return m_edge;
      default: return '0;
    endcase
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [W-1:0] exp_evt;
      exp_evt = m_prev & ~(m_lvl ^ m_edge);
      check(pin_oe, m_dir, "R3 pin_oe");
      check(pin_out, m_val, "R3 pin_out");
      check(edge_evt, exp_evt, "R9 edge_evt");
      check(bus_rdata, model_rd(), "R5 bus_rdata");
      check({6'd0, aux_lvl}, {6'd0, m_lvl[4], m_lvl[3]}, "R11 aux_lvl");
      for (int i = 0; i < W; i++) if (edge_evt[i]) evt_cnt[i]++;
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    check(bus_rdata, exp, tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < W; i++) evt_cnt[i] = 0;
  endtask

  initial begin
    clr_cnt();
    step(3);
    rst_n = 1'b1;
    step(1);
    @(negedge clk);
    // R1
    check(pin_oe, '0, "R1 oe after reset");
    check(pin_out, '0, "R1 out after reset");
    check(edge_evt, '0, "R1 no event after reset");
    @(posedge clk); #1;
    rd(2'd1, 8'h00, "R1 dir reset");
    rd(2'd2, 8'h00, "R1 edge reset");

    // R3 / R5
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hA5);
    pin_in = 8'h0C;
    step(3);
    @(negedge clk);
    check(pin_oe, 8'hF0, "R3 oe from dir");
    check(pin_out, 8'hA5, "R3 out from value");
    @(posedge clk); #1;
    rd(2'd0, 8'hAC, "R5 mixed readback");

    // R4
    wr(2'd0, 8'hFF);
    @(negedge clk);
    check(pin_oe, 8'hF0, "R4 oe unchanged by value write");
    @(posedge clk); #1;
    rd(2'd1, 8'hF0, "R4 dir unchanged");
    rd(2'd0, 8'hFC, "R4 input lines still show pad");

    // R2
    wr(2'd3, 8'h55);
    rd(2'd3, 8'h00, "R2 unused reads zero");
    rd(2'd1, 8'hF0, "R2 dir kept");
    rd(2'd2, 8'h00, "R2 edge kept");
    bus_sel = 1'b0;
    @(negedge clk);
    check(bus_rdata, '0, "R5 idle read zero");
    @(posedge clk); #1;

    // R6: bit0 goes high; visible only after two edges
    wr(2'd1, 8'h00);
    step(2);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
    pin_in = 8'h0D;
    @(posedge clk); #1;
    @(negedge clk);
    check(bus_rdata & 8'h01, 8'h00, "R6 one edge not yet visible");
    @(negedge clk);
    check(bus_rdata & 8'h01, 8'h01, "R6 visible after two edges");
    @(posedge clk); #1;
    bus_sel = 1'b0;

    // R7: falling select on bit1
    pin_in = 8'h02; step(4);
    clr_cnt();
    pin_in = 8'h00; step(4);
    check(evt_cnt[1][7:0], 8'd1, "R7 falling fires once");
    clr_cnt();
    pin_in = 8'h02; step(4);
    check(evt_cnt[1][7:0], 8'd0, "R7 rising silent");

    // R8: rising select on bit5
    wr(2'd2, 8'h20);
    step(3);
    clr_cnt();
    pin_in = 8'h22; step(4);
    check(evt_cnt[5][7:0], 8'd1, "R8 rising fires once");
    clr_cnt();
    pin_in = 8'h02; step(4);
    check(evt_cnt[5][7:0], 8'd0, "R8 falling silent");

    // R10: bit2 steady high, edge bit 0->1
    pin_in = 8'h06; step(4);
    clr_cnt();
    wr(2'd2, 8'h24);
    step(3);
    check(evt_cnt[2][7:0], 8'd1, "R10 edge rewrite fires");
    clr_cnt();
    wr(2'd2, 8'h20);
    step(3);
    check(evt_cnt[2][7:0], 8'd0, "R10 rewrite away from level silent");

    // R11
    pin_in = 8'h10; step(3);
    @(negedge clk);
    check({6'd0, aux_lvl}, 8'h02, "R11 aux line B");
    @(posedge clk); #1;
    pin_in = 8'h08; step(3);
    @(negedge clk);
    check({6'd0, aux_lvl}, 8'h01, "R11 aux line A");

    // R9: toggling every cycle never gives back-to-back pulses on one line
    for (int k = 0; k < 16; k++) begin
      pin_in = pin_in ^ 8'hFF;
      step(1);
    end
    step(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule